// File: doc/BRIEF.md
# Capability Load Tag Resolver

This block closes out a capability load at writeback. The memory read has already returned a capability and its validity tag. The page walk has already classified the page for capability loads. The block turns these into the final architectural effect of the instruction: what is written to the destination register, whether the instruction retires or faults, and whether a load reservation is placed.

Each input beat is qualified by a valid strobe. A beat carries:

- the loaded value and its tag,
- the load-capability permission of the authorizing capability,
- a two-bit page outcome code,
- a memory-exception flag with its cause code,
- the virtual address,
- a flag marking the load-reserved form of the instruction.

The resolved result appears on registered outputs exactly one cycle after the beat. A page marked for trapping only faults when the value coming back actually carries a set tag. Untagged data on such a page passes through as if nothing were special.

Top module: `cap_load_tag_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` and every output strobe are 0, and every output data field is 0.
- R2: A beat accepted on `in_valid` at a rising edge produces its result on the outputs after that same edge, with `out_valid` high for exactly that cycle. A cycle without `in_valid` produces all-zero outputs in the next cycle.
- R3: Outcome code 2'b00 (permitted) writes back the loaded data with tag = loaded tag AND `in_auth_permit_lc`, and raises `out_retire_ok`.
- R4: Outcome code 2'b01 (strip) writes back the loaded data with the tag forced to 0, and raises `out_retire_ok`.
- R5: Outcome code 2'b10 (trap) with the loaded tag set raises `out_exc_req` with cause `LC_FAULT_CAUSE` and `out_exc_addr` = the beat's virtual address. It also raises `out_retire_fail` and leaves `out_wb_en` at 0.
- R6: Outcome code 2'b10 with the loaded tag clear writes back the loaded data and tag unchanged (tag 0), and raises `out_retire_ok`.
- R7: A beat with `in_mem_exc` set reports `in_mem_cause` and the virtual address as the exception, retires as failed, and makes no writeback and no reservation, whatever the outcome code and tag.
- R8: A load-reserved beat that retires successfully (R3, R4 or R6) raises `out_resv_set` with `out_resv_addr` = the virtual address.
- R9: No reservation is set for a beat that is not load-reserved, or whose result is a fault. When no reservation is set, `out_resv_addr` is 0. `out_wb_data` is 0 without a writeback, and `out_exc_addr` and `out_exc_cause` are 0 without an exception.
- R10: Exactly one of `out_retire_ok` and `out_retire_fail` is high when `out_valid` is high, and neither when it is low. Outcome code 2'b11 is illegal on a valid beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier |
| in_cap_data | input | DATA_W | Loaded capability bits (without the tag) |
| in_cap_tag | input | 1 | Loaded validity tag |
| in_auth_permit_lc | input | 1 | Load-capability permission of the authorizing capability |
| in_lc_outcome | input | 2 | Page outcome: 00 permitted, 01 strip, 10 trap |
| in_mem_exc | input | 1 | The memory read raised an exception |
| in_mem_cause | input | CAUSE_W | Cause code of that exception |
| in_vaddr | input | ADDR_W | Virtual address of the access |
| in_load_resv | input | 1 | Load-reserved form of the instruction |
| out_valid | output | 1 | Result qualifier |
| out_wb_en | output | 1 | Write the destination register |
| out_wb_data | output | DATA_W | Data to write back |
| out_wb_tag | output | 1 | Resolved tag to write back |
| out_retire_ok | output | 1 | Instruction retires successfully |
| out_retire_fail | output | 1 | Instruction retires as failed |
| out_exc_req | output | 1 | Exception request |
| out_exc_cause | output | CAUSE_W | Exception cause |
| out_exc_addr | output | ADDR_W | Faulting virtual address |
| out_resv_set | output | 1 | Place a load reservation |
| out_resv_addr | output | ADDR_W | Reservation address |

## Verification
The bench goes after the trap outcome from both sides, with a tagged and an untagged value. A design that faulted on the untagged value would lose a legal data load. A design that passed the tagged value would leak a capability from a trapping page.

It pairs a set tag with a cleared permission under the permitted outcome. A missing AND would then write a live tag. It also tries a memory exception together with each outcome and a load-reserved flag. A wrong priority would write back data or set a reservation on a failed access.

Reservations are checked on the faulting trap case. Beats are run back to back and then followed by an idle cycle. This catches a reservation that leaks past a fault, and a result that is a cycle late or held over.

// File: rtl/clr_pkg.sv
package clr_pkg;

    // Page outcome code for capability loads
    typedef enum logic [1:0] {
        LC_PERMIT = 2'b00,
        LC_STRIP  = 2'b01,
        LC_TRAP   = 2'b10,
        LC_BAD    = 2'b11
    } lc_outcome_e;

endpackage

// File: rtl/clr_tag_decide.sv
// Decides the written-back tag and whether the page outcome raises a fault.
module clr_tag_decide
    import clr_pkg::*;
(
    input  lc_outcome_e outcome,
    input  logic        cap_tag,
    input  logic        permit_lc,
    output logic        tag_res,
    output logic        lc_fault
);

    always_comb begin
        tag_res  = 1'b0;
        lc_fault = 1'b0;
        unique case (outcome)
            LC_PERMIT: tag_res = cap_tag & permit_lc;
            LC_STRIP:  tag_res = 1'b0;
            LC_TRAP: begin
                // a tagged value faults; an untagged one passes as loaded
                lc_fault = cap_tag;
                tag_res  = 1'b0;
            end
            default: begin
                // illegal code: fail safe like a trapping page
                lc_fault = cap_tag;
                tag_res  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/clr_beat_resolve.sv
// Combines memory exception, page fault and reservation into the beat result.
module clr_beat_resolve #(
    parameter int unsigned                DATA_W         = 64,
    parameter int unsigned                ADDR_W         = 64,
    parameter int unsigned                CAUSE_W        = 5,
    parameter logic [CAUSE_W-1:0]         LC_FAULT_CAUSE = 5'd28
) (
    input  logic               valid,
    input  logic [DATA_W-1:0]  cap_data,
    input  logic               tag_res,
    input  logic               lc_fault,
    input  logic               mem_exc,
    input  logic [CAUSE_W-1:0] mem_cause,
    input  logic [ADDR_W-1:0]  vaddr,
    input  logic               load_resv,
    output logic               wb_en,
    output logic [DATA_W-1:0]  wb_data,
    output logic               wb_tag,
    output logic               retire_ok,
    output logic               retire_fail,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [ADDR_W-1:0]  exc_addr,
    output logic               resv_set,
    output logic [ADDR_W-1:0]  resv_addr
);

    always_comb begin
        wb_en       = 1'b0;
        wb_data     = '0;
        wb_tag      = 1'b0;
        retire_ok   = 1'b0;
        retire_fail = 1'b0;
        exc_req     = 1'b0;
        exc_cause   = '0;
        exc_addr    = '0;
        resv_set    = 1'b0;
        resv_addr   = '0;
        if (valid) begin
            if (mem_exc) begin
                // the read itself failed: report it unchanged
                exc_req     = 1'b1;
                exc_cause   = mem_cause;
                exc_addr    = vaddr;
                retire_fail = 1'b1;
            end else if (lc_fault) begin
                exc_req     = 1'b1;
                exc_cause   = LC_FAULT_CAUSE;
                exc_addr    = vaddr;
                retire_fail = 1'b1;
            end else begin
                wb_en     = 1'b1;
                wb_data   = cap_data;
                wb_tag    = tag_res;
                retire_ok = 1'b1;
                if (load_resv) begin
                    resv_set  = 1'b1;
                    resv_addr = vaddr;
                end
            end
        end
    end

endmodule

// File: rtl/cap_load_tag_resolver.sv
module cap_load_tag_resolver
    import clr_pkg::*;
#(
    parameter int unsigned        DATA_W         = 64,
    parameter int unsigned        ADDR_W         = 64,
    parameter int unsigned        CAUSE_W        = 5,
    parameter logic [CAUSE_W-1:0] LC_FAULT_CAUSE = 5'd28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [DATA_W-1:0]  in_cap_data,
    input  logic               in_cap_tag,
    input  logic               in_auth_permit_lc,
    input  logic [1:0]         in_lc_outcome,
    input  logic               in_mem_exc,
    input  logic [CAUSE_W-1:0] in_mem_cause,
    input  logic [ADDR_W-1:0]  in_vaddr,
    input  logic               in_load_resv,
    output logic               out_valid,
    output logic               out_wb_en,
    output logic [DATA_W-1:0]  out_wb_data,
    output logic               out_wb_tag,
    output logic               out_retire_ok,
    output logic               out_retire_fail,
    output logic               out_exc_req,
    output logic [CAUSE_W-1:0] out_exc_cause,
    output logic [ADDR_W-1:0]  out_exc_addr,
    output logic               out_resv_set,
    output logic [ADDR_W-1:0]  out_resv_addr
);

    typedef struct packed {
        logic               valid;
        logic               wb_en;
        logic [DATA_W-1:0]  wb_data;
        logic               wb_tag;
        logic               retire_ok;
        logic               retire_fail;
        logic               exc_req;
        logic [CAUSE_W-1:0] exc_cause;
        logic [ADDR_W-1:0]  exc_addr;
        logic               resv_set;
        logic [ADDR_W-1:0]  resv_addr;
    } result_t;

    result_t res_d, res_q;

    logic               tag_res_w;
    logic               lc_fault_w;
    logic               wb_en_w, wb_tag_w, ok_w, fail_w, exc_w, resv_w;
    logic [DATA_W-1:0]  wb_data_w;
    logic [CAUSE_W-1:0] cause_w;
    logic [ADDR_W-1:0]  exc_addr_w, resv_addr_w;

    clr_tag_decide u_decide (
        .outcome   (lc_outcome_e'(in_lc_outcome)),
        .cap_tag   (in_cap_tag),
        .permit_lc (in_auth_permit_lc),
        .tag_res   (tag_res_w),
        .lc_fault  (lc_fault_w)
    );

    clr_beat_resolve #(
        .DATA_W         (DATA_W),
        .ADDR_W         (ADDR_W),
        .CAUSE_W        (CAUSE_W),
        .LC_FAULT_CAUSE (LC_FAULT_CAUSE)
    ) u_resolve (
        .valid       (in_valid),
        .cap_data    (in_cap_data),
        .tag_res     (tag_res_w),
        .lc_fault    (lc_fault_w),
        .mem_exc     (in_mem_exc),
        .mem_cause   (in_mem_cause),
        .vaddr       (in_vaddr),
        .load_resv   (in_load_resv),
        .wb_en       (wb_en_w),
        .wb_data     (wb_data_w),
        .wb_tag      (wb_tag_w),
        .retire_ok   (ok_w),
        .retire_fail (fail_w),
        .exc_req     (exc_w),
        .exc_cause   (cause_w),
        .exc_addr    (exc_addr_w),
        .resv_set    (resv_w),
        .resv_addr   (resv_addr_w)
    );

    always_comb begin
        res_d             = '0;
        res_d.valid       = in_valid;
        res_d.wb_en       = wb_en_w;
        res_d.wb_data     = wb_data_w;
        res_d.wb_tag      = wb_tag_w;
        res_d.retire_ok   = ok_w;
        res_d.retire_fail = fail_w;
        res_d.exc_req     = exc_w;
        res_d.exc_cause   = cause_w;
        res_d.exc_addr    = exc_addr_w;
        res_d.resv_set    = resv_w;
        res_d.resv_addr   = resv_addr_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid       = res_q.valid;
    assign out_wb_en       = res_q.wb_en;
    assign out_wb_data     = res_q.wb_data;
    assign out_wb_tag      = res_q.wb_tag;
    assign out_retire_ok   = res_q.retire_ok;
    assign out_retire_fail = res_q.retire_fail;
    assign out_exc_req     = res_q.exc_req;
    assign out_exc_cause   = res_q.exc_cause;
    assign out_exc_addr    = res_q.exc_addr;
    assign out_resv_set    = res_q.resv_set;
    assign out_resv_addr   = res_q.resv_addr;

    // ---------------- assertions ----------------
    assert_outcome_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> in_lc_outcome != 2'b11);

    assert_retire_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones({out_retire_ok, out_retire_fail}) == 1);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_retire_ok && !out_retire_fail && !out_wb_en && !out_exc_req);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_trap_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_mem_exc && in_lc_outcome == 2'b10 && in_cap_tag
        |=> out_exc_req && out_exc_cause == LC_FAULT_CAUSE && !out_wb_en);

    assert_strip_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !in_mem_exc && in_lc_outcome == 2'b01 |=> out_wb_en && !out_wb_tag);

    assert_mem_exc_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_mem_exc |=> out_exc_req && out_exc_cause == $past(in_mem_cause)
                                   && !out_wb_en && !out_resv_set);

    assert_resv_on_success_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_resv_set |-> out_retire_ok && !out_exc_req);

endmodule

// File: tb/test_cap_load_tag_resolver.sv
module test_cap_load_tag_resolver;

    localparam int unsigned DW = 64;
    localparam int unsigned AW = 64;
    localparam int unsigned CW = 5;
    localparam logic [CW-1:0] FAULT = 5'd28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] in_cap_data = '0;
    logic          in_cap_tag = 1'b0;
    logic          in_auth_permit_lc = 1'b0;
    logic [1:0]    in_lc_outcome = 2'b00;
    logic          in_mem_exc = 1'b0;
    logic [CW-1:0] in_mem_cause = '0;
    logic [AW-1:0] in_vaddr = '0;
    logic          in_load_resv = 1'b0;
    logic          out_valid, out_wb_en, out_wb_tag, out_retire_ok, out_retire_fail;
    logic          out_exc_req, out_resv_set;
    logic [DW-1:0] out_wb_data;
    logic [CW-1:0] out_exc_cause;
    logic [AW-1:0] out_exc_addr, out_resv_addr;

    always #5 clk = ~clk;

    cap_load_tag_resolver #(.DATA_W(DW), .ADDR_W(AW), .CAUSE_W(CW), .LC_FAULT_CAUSE(FAULT))
    i_cap_load_tag_resolver (
        .clk, .rst_n, .in_valid, .in_cap_data, .in_cap_tag, .in_auth_permit_lc,
        .in_lc_outcome, .in_mem_exc, .in_mem_cause, .in_vaddr, .in_load_resv,
        .out_valid, .out_wb_en, .out_wb_data, .out_wb_tag, .out_retire_ok,
        .out_retire_fail, .out_exc_req, .out_exc_cause, .out_exc_addr,
        .out_resv_set, .out_resv_addr
    );

    typedef struct packed {
        logic       tag;
        logic       perm;
        logic [1:0] oc;
        logic       mexc;
        logic [4:0] mcause;
        logic       lres;
        logic       e_wb;
        logic       e_tag;
        logic       e_ok;
        logic       e_fail;
        logic       e_exc;
        logic [4:0] e_cause;
        logic       e_resv;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        // R3 permitted
        '{1'b1,1'b1,2'b00,1'b0,5'd0, 1'b0, 1'b1,1'b1,1'b1,1'b0,1'b0,5'd0, 1'b0},
        '{1'b1,1'b0,2'b00,1'b0,5'd0, 1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0,5'd0, 1'b1},
        '{1'b0,1'b1,2'b00,1'b0,5'd0, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,5'd0, 1'b0},
        // R4 strip
        '{1'b1,1'b1,2'b01,1'b0,5'd0, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,5'd0, 1'b0},
        '{1'b1,1'b1,2'b01,1'b0,5'd0, 1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0,5'd0, 1'b1},
        // R5 trap with tag, R9 no reservation on fault
        '{1'b1,1'b1,2'b10,1'b0,5'd0, 1'b0, 1'b0,1'b0,1'b0,1'b1,1'b1,5'd28,1'b0},
        '{1'b1,1'b1,2'b10,1'b0,5'd0, 1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1,5'd28,1'b0},
        // R6 trap without tag
        '{1'b0,1'b1,2'b10,1'b0,5'd0, 1'b1, 1'b1,1'b0,1'b1,1'b0,1'b0,5'd0, 1'b1},
        '{1'b0,1'b0,2'b10,1'b0,5'd0, 1'b0, 1'b1,1'b0,1'b1,1'b0,1'b0,5'd0, 1'b0},
        // R7 memory exception first
        '{1'b1,1'b1,2'b00,1'b1,5'd13,1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1,5'd13,1'b0},
        '{1'b1,1'b1,2'b10,1'b1,5'd5, 1'b0, 1'b0,1'b0,1'b0,1'b1,1'b1,5'd5, 1'b0},
        '{1'b0,1'b0,2'b01,1'b1,5'd7, 1'b1, 1'b0,1'b0,1'b0,1'b1,1'b1,5'd7, 1'b0}
    };

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic check(input bit good, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!good) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check(out_valid == 0, req, 64'(out_valid), 64'd0);
        check({out_wb_en, out_retire_ok, out_retire_fail, out_exc_req, out_resv_set} == 0,
              req, 64'({out_wb_en, out_retire_ok, out_retire_fail, out_exc_req, out_resv_set}), 64'd0);
        check(out_wb_data == 0 && out_exc_addr == 0 && out_resv_addr == 0 && out_exc_cause == 0
              && out_wb_tag == 0, req, out_wb_data | out_exc_addr | out_resv_addr, 64'd0);
    endtask

    function automatic logic [63:0] data_of(int i);
        return 64'hC0DE_0000_0000_0000 + 64'(i) * 64'h1111;
    endfunction

    function automatic logic [63:0] addr_of(int i);
        return 64'h0000_7F00_0000_0000 + 64'(i) * 64'h40;
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        in_valid = 1'b1;   // ignored while in reset
        in_cap_tag = 1'b1;
        @(negedge clk);
        check_idle("R1 valid ignored in reset");
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 first cycle after reset");

        // table walk, beats back to back (R2 latency)
        for (int i = 0; i < NV; i++) begin
            in_valid          = 1'b1;
            in_cap_data       = data_of(i);
            in_cap_tag        = VECS[i].tag;
            in_auth_permit_lc = VECS[i].perm;
            in_lc_outcome     = VECS[i].oc;
            in_mem_exc        = VECS[i].mexc;
            in_mem_cause      = VECS[i].mcause;
            in_vaddr          = addr_of(i);
            in_load_resv      = VECS[i].lres;
            @(negedge clk);
            check(out_valid == 1, $sformatf("R2 valid v%0d", i), 64'(out_valid), 64'd1);
            check(out_wb_en == VECS[i].e_wb, $sformatf("R3/R4/R6 wb_en v%0d", i),
                  64'(out_wb_en), 64'(VECS[i].e_wb));
            check(out_wb_tag == VECS[i].e_tag, $sformatf("R3/R4/R6 tag v%0d", i),
                  64'(out_wb_tag), 64'(VECS[i].e_tag));
            check(out_wb_data == (VECS[i].e_wb ? data_of(i) : 64'd0),
                  $sformatf("R9 wb_data v%0d", i), out_wb_data,
                  VECS[i].e_wb ? data_of(i) : 64'd0);
            check({out_retire_ok, out_retire_fail} == {VECS[i].e_ok, VECS[i].e_fail},
                  $sformatf("R10 retire v%0d", i), 64'({out_retire_ok, out_retire_fail}),
                  64'({VECS[i].e_ok, VECS[i].e_fail}));
            check(out_exc_req == VECS[i].e_exc && out_exc_cause == VECS[i].e_cause,
                  $sformatf("R5/R7 exception v%0d", i), 64'({out_exc_req, out_exc_cause}),
                  64'({VECS[i].e_exc, VECS[i].e_cause}));
            check(out_exc_addr == (VECS[i].e_exc ? addr_of(i) : 64'd0),
                  $sformatf("R5/R7 exc_addr v%0d", i), out_exc_addr,
                  VECS[i].e_exc ? addr_of(i) : 64'd0);
            check(out_resv_set == VECS[i].e_resv, $sformatf("R8/R9 resv v%0d", i),
                  64'(out_resv_set), 64'(VECS[i].e_resv));
            check(out_resv_addr == (VECS[i].e_resv ? addr_of(i) : 64'd0),
                  $sformatf("R8 resv_addr v%0d", i), out_resv_addr,
                  VECS[i].e_resv ? addr_of(i) : 64'd0);
        end

        // R2: idle cycle after a beat clears everything
        in_valid = 1'b0;
        @(negedge clk);
        check_idle("R2 idle after beat");

        // R7: memory exception with a clean permitted outcome still blocks writeback
        in_valid = 1'b1; in_cap_tag = 1'b0; in_auth_permit_lc = 1'b1; in_lc_outcome = 2'b00;
        in_mem_exc = 1'b1; in_mem_cause = 5'd31; in_vaddr = 64'hFFFF_FFFF_FFFF_FFC0;
        in_load_resv = 1'b1; in_cap_data = 64'h1;
        @(negedge clk);
        check(!out_wb_en && !out_resv_set && out_exc_cause == 5'd31 && out_retire_fail,
              "R7 corner", 64'({out_wb_en, out_resv_set, out_exc_cause, out_retire_fail}),
              64'({1'b0, 1'b0, 5'd31, 1'b1}));
        check(out_exc_addr == 64'hFFFF_FFFF_FFFF_FFC0, "R7 corner addr", out_exc_addr,
              64'hFFFF_FFFF_FFFF_FFC0);
        in_valid = 1'b0; in_mem_exc = 1'b0;
        @(negedge clk);
        check_idle("R2 idle after exception");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule